// File: doc/BRIEF.md
# Timer Channel Capture/Compare Register

This block is the storage for one channel of a 16-bit timer as seen by an 8-bit processor bus. A single 16-bit word serves two purposes chosen by a 2-bit mode input. In capture mode it latches the free-running counter whenever a capture strobe arrives. In compare mode it holds a target value, and the channel signals a match when the counter reaches that value. Both kinds of event set a sticky channel flag, which software clears with a dedicated strobe.

Software reaches the word one byte at a time, using a high/low select. To keep each 16-bit transfer coherent, touching the high byte arms an interlock that the matching low-byte access releases. In capture mode, a high-byte read freezes the word against new captures until the low byte has been read. In compare mode, a high-byte write is parked in a holding latch, and compares are suspended until the low-byte write commits both bytes at once. Reset does not define the word, so software loads it before use. The counter, edge detection, pin logic and interrupts lie outside the block.

Top module: `tmr_chan_reg`

## Requirements
- R1: With `mode_i` = 2'b00 (capture mode) and no interlock, a `cap_stb_i` pulse loads `cnt_i` into the word at the next clock edge and sets `flag_o`. The word is always visible on `bus_rdata_o`: bits 15..8 when `bus_hi_i` = 1 and bits 7..0 when `bus_hi_i` = 0.
- R2: A high-byte write (`bus_wr_i` = 1, `bus_hi_i` = 1) only loads a holding latch and leaves the word unchanged. A low-byte write (`bus_wr_i` = 1, `bus_hi_i` = 0) commits {held byte, `bus_wdata_i`} to the word at the next edge.
- R3: In capture mode, a high-byte read (`bus_rd_i` = 1, `bus_hi_i` = 1) blocks captures, including a capture in the same cycle, up to and including the cycle of the next low-byte read. A blocked capture is dropped: the word and `flag_o` stay unchanged and nothing is replayed later.
- R4: With `mode_i` other than 2'b00 (compare mode) and no interlock, a cycle in which `cnt_i` equals the word makes `match_o` high for the following cycle only and sets `flag_o`.
- R5: In compare mode, a high-byte write suppresses matches and flag setting from that cycle up to and including the cycle of the next low-byte write.
- R6: `flag_clr_i` clears `flag_o` at the next edge. A capture or match in the same cycle takes priority, so the flag stays set.
- R7: When a low-byte write and an accepted capture strobe fall in the same cycle, the write wins. The capture is discarded and does not set the flag.
- R8: Reset clears `flag_o`, `match_o` and both interlocks. Any change of `mode_i` clears both interlocks at the next edge. In the cycle of the change, a lock that was already armed still applies.
- R9: A high-byte write in capture mode does not block captures, and a high-byte read in compare mode does not block matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Free-running counter value |
| cap_stb_i | input | 1 | Capture edge strobe, one cycle |
| mode_i | input | 2 | 2'b00 capture, any other value compare |
| bus_rd_i | input | 1 | Byte read strobe |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_hi_i | input | 1 | 1 selects the high byte, 0 the low byte |
| bus_wdata_i | input | 8 | Write data byte |
| flag_clr_i | input | 1 | Clears the channel flag |
| bus_rdata_o | output | 8 | Selected byte of the word |
| match_o | output | 1 | One-cycle compare match pulse |
| flag_o | output | 1 | Sticky channel flag |

## Verification
Several pairs of functions can land in the same cycle: a capture strobe with a high-byte read or a low-byte write, a compare hit with a flag clear, and a compare hit with a high-byte write or a mode change. Directed sequences place each pair on one cycle. A long random run with a fixed seed then mixes strobes, byte accesses, clears and mode changes, and biases the counter toward the stored value so that hits collide with other events often. A bench model, written from the priority rules in the requirements, predicts the flag, the match pulse and every byte read, and each cycle's outputs are compared against it.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int MODE_W = 2;

    typedef enum logic {
        KIND_CAPTURE = 1'b0,
        KIND_COMPARE = 1'b1
    } chan_kind_e;

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic wr_hi;
        logic wr_lo;
    } byte_evt_t;

    function automatic chan_kind_e kind_of(input logic [MODE_W-1:0] m);
        return (m == '0) ? KIND_CAPTURE : KIND_COMPARE;
    endfunction

    function automatic byte_evt_t decode_evt(input logic rd, input logic wr, input logic hi);
        byte_evt_t e;
        e.rd_hi = rd & hi;
        e.rd_lo = rd & ~hi;
        e.wr_hi = wr & hi;
        e.wr_lo = wr & ~hi;
        return e;
    endfunction

endpackage

// File: rtl/tcc_byte_port.sv
module tcc_byte_port
    import tcc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  byte_evt_t                evt_i,
    input  logic                     hi_i,
    input  logic [BYTE_W-1:0]        wdata_i,
    input  logic [LANES*BYTE_W-1:0]  word_i,
    output logic                     commit_o,
    output logic [LANES*BYTE_W-1:0]  commit_val_o,
    output logic [BYTE_W-1:0]        rdata_o
);
    localparam int UPPER_W = (LANES - 1) * BYTE_W;

    logic [UPPER_W-1:0] hold_q;

    // High-byte writes park in the holding latch; nothing reaches the word yet.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (evt_i.wr_hi) begin
            hold_q <= {hold_q[UPPER_W-1:0], wdata_i} >> 0;
        end
    end

    assign commit_o     = evt_i.wr_lo;
    assign commit_val_o = {hold_q, wdata_i};

    // Byte lanes of the word for the read mux.
    logic [BYTE_W-1:0] lane [LANES];
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign rdata_o = hi_i ? lane[LANES-1] : lane[0];

endmodule

// File: rtl/tcc_interlock.sv
module tcc_interlock
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_kind_e kind_i,
    input  logic       mode_chg_i,
    input  byte_evt_t  evt_i,
    output logic       cap_lock_o,
    output logic       cmp_lock_o
);
    always_ff @(posedge clk) begin
        if (rst || mode_chg_i) begin
            cap_lock_o <= 1'b0;
            cmp_lock_o <= 1'b0;
        end else if (kind_i == KIND_CAPTURE) begin
            cmp_lock_o <= 1'b0;
            if (evt_i.rd_lo) begin
                cap_lock_o <= 1'b0;
            end else if (evt_i.rd_hi) begin
                cap_lock_o <= 1'b1;
            end
        end else begin
            cap_lock_o <= 1'b0;
            if (evt_i.wr_lo) begin
                cmp_lock_o <= 1'b0;
            end else if (evt_i.wr_hi) begin
                cmp_lock_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcc_event_flag.sv
module tcc_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic cap_ok_i,
    input  logic clr_i,
    output logic match_o,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            match_o <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            match_o <= hit_i;
            if (hit_i || cap_ok_i) begin
                flag_o <= 1'b1;
            end else if (clr_i) begin
                flag_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_chan_reg.sv
module tmr_chan_reg
    import tcc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES*BYTE_W-1:0]  cnt_i,
    input  logic                     cap_stb_i,
    input  logic [MODE_W-1:0]        mode_i,
    input  logic                     bus_rd_i,
    input  logic                     bus_wr_i,
    input  logic                     bus_hi_i,
    input  logic [BYTE_W-1:0]        bus_wdata_i,
    input  logic                     flag_clr_i,
    output logic [BYTE_W-1:0]        bus_rdata_o,
    output logic                     match_o,
    output logic                     flag_o
);
    localparam int REG_W = LANES * BYTE_W;

    byte_evt_t        evt;
    chan_kind_e       kind;
    logic [MODE_W-1:0] mode_q;
    logic             mode_chg;
    logic [REG_W-1:0] value_q;
    logic             commit;
    logic [REG_W-1:0] commit_val;
    logic             cap_lock;
    logic             cmp_lock;
    logic             cap_ok;
    logic             hit;

    assign evt      = decode_evt(bus_rd_i, bus_wr_i, bus_hi_i);
    assign kind     = kind_of(mode_i);
    assign mode_chg = (mode_i != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_i;
        end
    end

    tcc_byte_port #(.BYTE_W(BYTE_W), .LANES(LANES)) u_port (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .hi_i         (bus_hi_i),
        .wdata_i      (bus_wdata_i),
        .word_i       (value_q),
        .commit_o     (commit),
        .commit_val_o (commit_val),
        .rdata_o      (bus_rdata_o)
    );

    tcc_interlock u_lock (
        .clk        (clk),
        .rst        (rst),
        .kind_i     (kind),
        .mode_chg_i (mode_chg),
        .evt_i      (evt),
        .cap_lock_o (cap_lock),
        .cmp_lock_o (cmp_lock)
    );

    // A high read in the same cycle already protects the pair; a low write wins over a capture.
    assign cap_ok = (kind == KIND_CAPTURE) && cap_stb_i && !cap_lock && !evt.rd_hi && !evt.wr_lo;

    // A high write in the same cycle already suspends the compare.
    assign hit = (kind == KIND_COMPARE) && !cmp_lock && !evt.wr_hi && (cnt_i == value_q);

    // Word contents are left undefined by reset.
    always_ff @(posedge clk) begin
        if (commit) begin
            value_q <= commit_val;
        end else if (cap_ok) begin
            value_q <= cnt_i;
        end
    end

    tcc_event_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (hit),
        .cap_ok_i (cap_ok),
        .clr_i    (flag_clr_i),
        .match_o  (match_o),
        .flag_o   (flag_o)
    );

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              mode_i,
    input logic                    bus_wr_i,
    input logic                    bus_hi_i,
    input logic                    flag_clr_i,
    input logic [LANES*BYTE_W-1:0] cnt_i,
    input logic [LANES*BYTE_W-1:0] value_q,
    input logic                    cap_lock,
    input logic                    cmp_lock,
    input logic                    match_o,
    input logic                    flag_o
);
    p_cap_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 && cap_lock && !(bus_wr_i && !bus_hi_i)) |=> $stable(value_q));

    p_cap_no_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 && cap_lock && !flag_o) |=> !flag_o);

    p_hold_only_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'b00 && bus_wr_i && bus_hi_i) |=> $stable(value_q));

    p_match_eq_r4: assert property (@(posedge clk) disable iff (rst)
        match_o |-> ($past(cnt_i) == $past(value_q)));

    p_match_flag_r4: assert property (@(posedge clk) disable iff (rst)
        match_o |-> flag_o);

    p_cmp_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_lock || (mode_i != 2'b00 && bus_wr_i && bus_hi_i)) |=> !match_o);

    p_flag_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_o) |-> $past(flag_clr_i));

    p_locks_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap_lock, cmp_lock}));
endmodule

bind tmr_chan_reg tcc_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .bus_wr_i   (bus_wr_i),
    .bus_hi_i   (bus_hi_i),
    .flag_clr_i (flag_clr_i),
    .cnt_i      (cnt_i),
    .value_q    (value_q),
    .cap_lock   (cap_lock),
    .cmp_lock   (cmp_lock),
    .match_o    (match_o),
    .flag_o     (flag_o)
);

// File: tb/tb_tmr_chan_reg.sv
`timescale 1ns/1ps
module tb_tmr_chan_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_i;
    logic        cap_stb_i;
    logic [1:0]  mode_i;
    logic        bus_rd_i, bus_wr_i, bus_hi_i;
    logic [7:0]  bus_wdata_i;
    logic        flag_clr_i;
    logic [7:0]  bus_rdata_o;
    logic        match_o, flag_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_chan_reg dut (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .cap_stb_i(cap_stb_i), .mode_i(mode_i),
        .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_hi_i(bus_hi_i),
        .bus_wdata_i(bus_wdata_i), .flag_clr_i(flag_clr_i),
        .bus_rdata_o(bus_rdata_o), .match_o(match_o), .flag_o(flag_o)
    );

    // Behavioural model state
    logic [15:0] m_val;
    logic [7:0]  m_hold;
    bit          m_known, m_cl, m_ol, m_flag, m_match;
    logic [1:0]  m_prev;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic hi);
        return hi ? m_val[15:8] : m_val[7:0];
    endfunction

    task automatic model_reset();
        m_hold = 8'h00; m_known = 0; m_cl = 0; m_ol = 0;
        m_flag = 0; m_match = 0; m_prev = 2'b00;
    endtask

    task automatic do_reset();
        rst = 1'b1; cap_stb_i = 0; bus_rd_i = 0; bus_wr_i = 0; bus_hi_i = 0;
        bus_wdata_i = 0; flag_clr_i = 0; cnt_i = 0; mode_i = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        model_reset();
    endtask

    // One clock cycle: drive, check read data, advance model, tick, check outputs.
    task automatic cyc(input string tag, input logic [1:0] md, input logic [15:0] c,
                       input logic stb, input logic rd, input logic wr, input logic hi,
                       input logic [7:0] wd, input logic clr, output logic [7:0] rdv);
        bit capm, wlo, whi, rhi, rlo, cap_ok, hit;
        mode_i = md; cnt_i = c; cap_stb_i = stb; bus_rd_i = rd; bus_wr_i = wr;
        bus_hi_i = hi; bus_wdata_i = wd; flag_clr_i = clr;
        #1;
        rdv = bus_rdata_o;
        if (rd && m_known) check({tag, " read"}, {8'h00, bus_rdata_o}, {8'h00, exp_byte(hi)});
        capm = (md == 2'b00);
        wlo = wr & ~hi; whi = wr & hi; rhi = rd & hi; rlo = rd & ~hi;
        cap_ok = capm && stb && !m_cl && !rhi && !wlo;
        hit = !capm && !m_ol && !whi && m_known && (c == m_val);
        if (wlo) begin m_val = {m_hold, wd}; m_known = 1; end
        else if (cap_ok) begin m_val = c; m_known = 1; end
        if (whi) m_hold = wd;
        if (md != m_prev) begin m_cl = 0; m_ol = 0; end
        else if (capm) begin
            m_ol = 0;
            if (rlo) m_cl = 0; else if (rhi) m_cl = 1;
        end else begin
            m_cl = 0;
            if (wlo) m_ol = 0; else if (whi) m_ol = 1;
        end
        if (cap_ok || hit) m_flag = 1; else if (clr) m_flag = 0;
        m_match = hit;
        m_prev = md;
        @(posedge clk); #1;
        check({tag, " flag"}, {15'd0, flag_o}, {15'd0, m_flag});
        check({tag, " match"}, {15'd0, match_o}, {15'd0, m_match});
    endtask

    logic [7:0] rv, rh, rl;

    task automatic idle(input string tag, input logic [1:0] md, input logic [15:0] c);
        cyc(tag, md, c, 0, 0, 0, 0, 8'h00, 0, rv);
    endtask

    task automatic wr16(input string tag, input logic [1:0] md, input logic [15:0] c, input logic [15:0] v);
        cyc(tag, md, c, 0, 0, 1, 1, v[15:8], 0, rv);
        cyc(tag, md, c, 0, 0, 1, 0, v[7:0], 0, rv);
    endtask

    task automatic rd16(input string tag, input logic [1:0] md, input logic [15:0] c, output logic [15:0] v);
        cyc(tag, md, c, 0, 1, 0, 1, 8'h00, 0, rh);
        cyc(tag, md, c, 0, 1, 0, 0, 8'h00, 0, rl);
        v = {rh, rl};
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        int pulses;
        void'($urandom(32'h5EED_0C0D));
        do_reset();
        // R8: reset state
        check("R8 reset flag", {15'd0, flag_o}, 16'd0);
        check("R8 reset match", {15'd0, match_o}, 16'd0);

        // R2: high write only to holding latch, low write commits
        wr16("R2", 2'b00, 16'h0000, 16'h1234);
        rd16("R2", 2'b00, 16'h0000, w);
        check("R2 commit", w, 16'h1234);
        cyc("R2", 2'b00, 16'h0000, 0, 0, 1, 1, 8'hAB, 0, rv);
        rd16("R2", 2'b00, 16'h0000, w);
        check("R2 hold only", w, 16'h1234);
        cyc("R2", 2'b00, 16'h0000, 0, 0, 1, 0, 8'hCD, 0, rv);
        rd16("R2", 2'b00, 16'h0000, w);
        check("R2 pair", w, 16'hABCD);

        // R1: capture
        cyc("R1", 2'b00, 16'hBEEF, 1, 0, 0, 0, 8'h00, 0, rv);
        check("R1 flag set", {15'd0, flag_o}, 16'd1);
        rd16("R1", 2'b00, 16'h0000, w);
        check("R1 captured", w, 16'hBEEF);

        // R6: clear
        cyc("R6", 2'b00, 16'h0000, 0, 0, 0, 0, 8'h00, 1, rv);
        check("R6 cleared", {15'd0, flag_o}, 16'd0);

        // R3: high read locks; capture dropped; same-cycle high read also blocks
        cyc("R3", 2'b00, 16'h1111, 1, 1, 0, 1, 8'h00, 0, rh);
        check("R3 high byte", {8'h00, rh}, 16'h00BE);
        cyc("R3", 2'b00, 16'h2222, 1, 0, 0, 0, 8'h00, 0, rv);
        check("R3 no flag", {15'd0, flag_o}, 16'd0);
        cyc("R3", 2'b00, 16'h3333, 1, 1, 0, 0, 8'h00, 0, rl);
        check("R3 coherent low", {8'h00, rl}, 16'h00EF);
        cyc("R3", 2'b00, 16'h4444, 1, 0, 0, 0, 8'h00, 0, rv);
        rd16("R3", 2'b00, 16'h0000, w);
        check("R3 reopened", w, 16'h4444);

        // R7: low write beats same-cycle capture
        cyc("R7", 2'b00, 16'h0000, 0, 0, 0, 0, 8'h00, 1, rv);
        cyc("R7", 2'b00, 16'h0000, 0, 0, 1, 1, 8'h56, 0, rv);
        cyc("R7", 2'b00, 16'h9999, 1, 0, 1, 0, 8'h78, 0, rv);
        check("R7 no flag", {15'd0, flag_o}, 16'd0);
        rd16("R7", 2'b00, 16'h0000, w);
        check("R7 write wins", w, 16'h5678);

        // R9: high write in capture mode does not block capture
        cyc("R9", 2'b00, 16'h0000, 0, 0, 1, 1, 8'h00, 0, rv);
        cyc("R9", 2'b00, 16'h7777, 1, 0, 0, 0, 8'h00, 0, rv);
        rd16("R9", 2'b00, 16'h0000, w);
        check("R9 capture kept", w, 16'h7777);

        // R8: reset clears capture lock
        cyc("R8", 2'b00, 16'h0000, 0, 1, 0, 1, 8'h00, 1, rv);
        do_reset();
        m_known = 1; // word itself is not touched by reset; model keeps 16'h7777
        m_val = 16'h7777;
        cyc("R8", 2'b00, 16'h5A5A, 1, 0, 0, 0, 8'h00, 0, rv);
        check("R8 lock cleared by reset", {15'd0, flag_o}, 16'd1);

        // R4: compare sweep
        cyc("R4", 2'b01, 16'h0000, 0, 0, 0, 0, 8'h00, 1, rv);
        wr16("R4", 2'b01, 16'h0000, 16'h0040);
        pulses = 0;
        for (int i = 16'h3C; i <= 16'h44; i++) begin
            cyc("R4", 2'b01, i[15:0], 0, 0, 0, 0, 8'h00, 0, rv);
            if (match_o) pulses++;
        end
        check("R4 single pulse", pulses[15:0], 16'd1);
        check("R4 flag", {15'd0, flag_o}, 16'd1);

        // R5: high write suppresses compare until low write
        cyc("R5", 2'b01, 16'h0000, 0, 0, 0, 0, 8'h00, 1, rv);
        cyc("R5", 2'b01, 16'h0040, 0, 0, 1, 1, 8'h00, 0, rv);
        check("R5 same-cycle suppressed", {15'd0, match_o}, 16'd0);
        idle("R5", 2'b01, 16'h0040);
        idle("R5", 2'b01, 16'h0040);
        check("R5 locked no flag", {15'd0, flag_o}, 16'd0);
        cyc("R5", 2'b01, 16'h0040, 0, 0, 1, 0, 8'h60, 0, rv);
        check("R5 commit cycle quiet", {15'd0, match_o}, 16'd0);
        idle("R5", 2'b01, 16'h0060);
        check("R5 new value matches", {15'd0, match_o}, 16'd1);

        // R6: set beats clear
        cyc("R6", 2'b01, 16'h0060, 0, 0, 0, 0, 8'h00, 1, rv);
        check("R6 set wins", {15'd0, flag_o}, 16'd1);
        cyc("R6", 2'b01, 16'h0000, 0, 0, 0, 0, 8'h00, 1, rv);
        check("R6 clear", {15'd0, flag_o}, 16'd0);

        // R8: mode change releases compare lock
        cyc("R8", 2'b01, 16'h0000, 0, 0, 1, 1, 8'h77, 0, rv);
        idle("R8", 2'b10, 16'h0060);
        check("R8 change cycle still locked", {15'd0, match_o}, 16'd0);
        idle("R8", 2'b10, 16'h0060);
        check("R8 released", {15'd0, match_o}, 16'd1);

        // R9: high read in compare mode does not block
        cyc("R9", 2'b10, 16'h0060, 0, 1, 0, 1, 8'h00, 0, rv);
        check("R9 match on read", {15'd0, match_o}, 16'd1);
        cyc("R9", 2'b10, 16'h0000, 0, 1, 0, 0, 8'h00, 1, rv);

        // Random mix, all requirements R1 to R9 judged by the model
        for (int n = 0; n < 4000; n++) begin
            logic [1:0]  md;
            logic [15:0] c;
            logic        rd, wr, hi;
            md = m_prev;
            if ($urandom_range(0, 63) == 0) md = 2'($urandom_range(0, 3));
            c = ($urandom_range(0, 3) == 0) ? m_val : 16'($urandom);
            rd = ($urandom_range(0, 3) == 0);
            wr = !rd && ($urandom_range(0, 5) == 0);
            hi = $urandom_range(0, 1) == 1;
            cyc("RND", md, c, $urandom_range(0, 2) == 0, rd, wr, hi,
                8'($urandom), $urandom_range(0, 7) == 0, rv);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule